// File: doc/BRIEF.md
# NOR Flash Command Sequencer

This block drives a flash data bus built from several 16-bit NOR flash devices wired side by side. By default there are two devices, which gives a 32-bit word. Every command is written to all devices at once, so each 16-bit lane carries the same command byte in its low half.

A host starts one of three operations with a one-cycle `start` pulse:
- word program,
- block erase,
- identifier probe.

The sequencer then:
1. issues the command writes for that operation;
2. polls the status word until every device reports that its internal write engine is idle;
3. always puts the devices back into array-read mode;
4. judges the outcome and reports it with a one-cycle `done` pulse, with `err` qualified by `done`.

A program is also read back after the return to array mode and compared with the written data.

The flash side is a synchronous single-cycle strobe bus. Each `fl_wr` cycle writes `fl_wdata` to `fl_addr`. Each `fl_rd` cycle requests a read, and the read data is returned on `fl_rdata` in the following cycle. Pin timing and data-line remapping belong to the layer below this block.

Top module: `nor_cmd_seq`

## Requirements
- R1: An erase (req_op = 2'b01) writes 0x00200020 and then 0x00D000D0, both to the request address. After it succeeds, the block holding that address reads as all ones.
- R2: A program (req_op = 2'b00) writes 0x00400040 and then the request data, both to the request address.
- R3: After the command writes, the block repeats a poll: write 0x00700070, then read the status. It leaves the poll only when bit 7 of every 16-bit lane is set (mask 0x00800080). Each extra poll adds 3 cycles.
- R4: Once polling ends, 0x00FF00FF is written before the result is judged, so the devices are in array-read mode when done is raised.
- R5: An erase reports err when any bit of 0x00200020 is set in the final status, and ignores 0x00100010. A program reports err when any bit of 0x00100010 is set, and ignores 0x00200020.
- R6: A program reads back its address after the array-read command and reports err if the word differs from the written data.
- R7: A probe (req_op = 2'b10) writes 0x00900090 to word 0, reads word 0 and then word 1, and writes 0x00FF00FF. It passes only if word 0 is 0x00890089 and word 1 is either 0x88F388F3 or 0x88F488F4.
- R8: start is accepted only while idle and with req_op other than 2'b11. Any other start causes no bus activity and no done.
- R9: done is high for exactly one cycle, and err is valid only with done. Counting the clock edge that samples start as the first, done is seen after these numbers of edges, where P is the number of polls:
  - erase: 4 + 3·P
  - program: 6 + 3·P
  - probe: 7
- R10: If the status is still not ready after POLL_MAX polls, the operation ends with err. The array-read command is still written, with latency P = POLL_MAX.
- R11: During reset and while idle, done, err, fl_wr and fl_rd are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request strobe, sampled while idle |
| req_op | input | 2 | 00 program, 01 erase, 10 probe, 11 ignored |
| req_addr | input | AW | Word address of the target |
| req_data | input | NDEV*16 | Word to program |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Failure flag, valid with done |
| fl_wr | output | 1 | Flash write strobe |
| fl_rd | output | 1 | Flash read strobe |
| fl_addr | output | AW | Flash word address |
| fl_wdata | output | NDEV*16 | Flash write data |
| fl_rdata | input | NDEV*16 | Flash read data, valid the cycle after fl_rd |

## Verification
Each result has a fixed due time. Done arrives 4 + 3·P edges after the accepting edge for an erase, 6 + 3·P for a program and 7 for a probe. The bench's flash model decides P, because it answers "busy" for a set number of status reads.

The bench drives inputs on the falling edge and counts rising edges from the one that samples start. It checks the count when done first shows at a falling edge, and samples err in that same cycle. It then checks one cycle later that done has dropped, and checks the model's read mode and memory contents after the operation has ended.

// File: rtl/nfseq_pkg.sv
package nfseq_pkg;
    localparam int LANE_W = 16;

    typedef enum logic [1:0] {
        OP_PROG  = 2'd0,
        OP_ERASE = 2'd1,
        OP_PROBE = 2'd2
    } op_e;

    localparam logic [7:0] CMD_ARRAY  = 8'hFF;
    localparam logic [7:0] CMD_IDREAD = 8'h90;
    localparam logic [7:0] CMD_ESETUP = 8'h20;
    localparam logic [7:0] CMD_ECONF  = 8'hD0;
    localparam logic [7:0] CMD_PSETUP = 8'h40;
    localparam logic [7:0] CMD_STATUS = 8'h70;

    localparam int BIT_READY = 7;
    localparam int BIT_EERR  = 5;
    localparam int BIT_PERR  = 4;

    localparam logic [LANE_W-1:0] MFR_CODE = 16'h0089;
    localparam logic [LANE_W-1:0] DEV_TOP  = 16'h88F3;
    localparam logic [LANE_W-1:0] DEV_BOT  = 16'h88F4;

    typedef enum logic [3:0] {
        S_IDLE, S_CMD1, S_CMD2, S_PWR, S_PRD, S_PCHK, S_ARR,
        S_VRD, S_VCHK, S_IRD0, S_ICHK0, S_IRD1, S_ICHK1
    } st_e;
endpackage

// File: rtl/nfseq_judge.sv
module nfseq_judge
    import nfseq_pkg::*;
#(
    parameter int NDEV = 2
) (
    input  logic [NDEV*LANE_W-1:0] word,
    output logic                   all_ready,
    output logic                   any_eerr,
    output logic                   any_perr,
    output logic                   mfr_ok,
    output logic                   dev_ok
);
    logic [NDEV-1:0] rdy, eerr, perr, mfr, same;
    logic [LANE_W-1:0] lane0;

    assign lane0 = word[LANE_W-1:0];

    for (genvar g = 0; g < NDEV; g++) begin : g_lane
        logic [LANE_W-1:0] lane;
        assign lane    = word[g*LANE_W +: LANE_W];
        assign rdy[g]  = lane[BIT_READY];
        assign eerr[g] = lane[BIT_EERR];
        assign perr[g] = lane[BIT_PERR];
        assign mfr[g]  = (lane == MFR_CODE);
        assign same[g] = (lane == lane0);
    end

    assign all_ready = &rdy;
    assign any_eerr  = |eerr;
    assign any_perr  = |perr;
    assign mfr_ok    = &mfr;
    assign dev_ok    = ((lane0 == DEV_TOP) || (lane0 == DEV_BOT)) && (&same);
endmodule

// File: rtl/nfseq_poll_ctr.sv
module nfseq_poll_ctr #(
    parameter int POLL_MAX = 1000,
    localparam int CW = $clog2(POLL_MAX + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          inc,
    output logic [CW-1:0] cnt,
    output logic          at_limit
);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr)
            cnt_d = '0;
        else if (inc && (cnt_q != CW'(POLL_MAX)))
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt      = cnt_q;
    assign at_limit = (cnt_q == CW'(POLL_MAX));

    // R10
    poll_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(POLL_MAX));

    // R10
    poll_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt_q == '0));
endmodule

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq
    import nfseq_pkg::*;
#(
    parameter int NDEV     = 2,
    parameter int AW       = 20,
    parameter int POLL_MAX = 1000,
    localparam int DW = NDEV * LANE_W,
    localparam int CW = $clog2(POLL_MAX + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [1:0]    req_op,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_data,
    output logic          done,
    output logic          err,
    output logic          fl_wr,
    output logic          fl_rd,
    output logic [AW-1:0] fl_addr,
    output logic [DW-1:0] fl_wdata,
    input  logic [DW-1:0] fl_rdata
);
    typedef struct packed {
        st_e           st;
        op_e           op;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
        logic          err;
        logic          done;
    } seq_t;

    function automatic logic [DW-1:0] rep(input logic [7:0] c);
        logic [DW-1:0] w;
        for (int i = 0; i < NDEV; i++)
            w[i*LANE_W +: LANE_W] = {{(LANE_W-8){1'b0}}, c};
        return w;
    endfunction

    localparam logic [DW-1:0] W_ARRAY  = rep(CMD_ARRAY);
    localparam logic [DW-1:0] W_STATUS = rep(CMD_STATUS);

    seq_t r_q, r_d;
    logic [7:0] cmd;
    logic       use_data, clr, inc;
    logic       all_ready, any_eerr, any_perr, mfr_ok, dev_ok, at_limit;
    logic [CW-1:0] poll_cnt;

    nfseq_judge #(.NDEV(NDEV)) u_judge (
        .word(fl_rdata), .all_ready(all_ready), .any_eerr(any_eerr),
        .any_perr(any_perr), .mfr_ok(mfr_ok), .dev_ok(dev_ok)
    );

    nfseq_poll_ctr #(.POLL_MAX(POLL_MAX)) u_poll (
        .clk(clk), .rst_n(rst_n), .clr(clr), .inc(inc),
        .cnt(poll_cnt), .at_limit(at_limit)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        fl_wr    = 1'b0;
        fl_rd    = 1'b0;
        cmd      = CMD_ARRAY;
        use_data = 1'b0;
        clr      = 1'b0;
        inc      = 1'b0;
        unique case (r_q.st)
            S_IDLE: begin
                if (start && (req_op != 2'b11)) begin
                    r_d.op   = op_e'(req_op);
                    r_d.addr = (req_op == OP_PROBE) ? '0 : req_addr;
                    r_d.data = req_data;
                    r_d.err  = 1'b0;
                    r_d.st   = S_CMD1;
                    clr      = 1'b1;
                end
            end
            S_CMD1: begin
                fl_wr = 1'b1;
                cmd   = (r_q.op == OP_PROG)  ? CMD_PSETUP :
                        (r_q.op == OP_ERASE) ? CMD_ESETUP : CMD_IDREAD;
                r_d.st = (r_q.op == OP_PROBE) ? S_IRD0 : S_CMD2;
            end
            S_CMD2: begin
                fl_wr    = 1'b1;
                cmd      = CMD_ECONF;
                use_data = (r_q.op == OP_PROG);
                r_d.st   = S_PWR;
            end
            S_PWR: begin
                fl_wr  = 1'b1;
                cmd    = CMD_STATUS;
                inc    = 1'b1;
                r_d.st = S_PRD;
            end
            S_PRD: begin
                fl_rd  = 1'b1;
                r_d.st = S_PCHK;
            end
            S_PCHK: begin
                if (all_ready) begin
                    r_d.err = (r_q.op == OP_PROG) ? any_perr : any_eerr;
                    r_d.st  = S_ARR;
                end else if (at_limit) begin
                    r_d.err = 1'b1;
                    r_d.st  = S_ARR;
                end else begin
                    r_d.st  = S_PWR;
                end
            end
            S_ARR: begin
                fl_wr = 1'b1;
                cmd   = CMD_ARRAY;
                if (r_q.op == OP_PROG) begin
                    r_d.st = S_VRD;
                end else begin
                    r_d.st   = S_IDLE;
                    r_d.done = 1'b1;
                end
            end
            S_VRD: begin
                fl_rd  = 1'b1;
                r_d.st = S_VCHK;
            end
            S_VCHK: begin
                if (fl_rdata != r_q.data) r_d.err = 1'b1;
                r_d.done = 1'b1;
                r_d.st   = S_IDLE;
            end
            S_IRD0: begin
                fl_rd  = 1'b1;
                r_d.st = S_ICHK0;
            end
            S_ICHK0: begin
                if (!mfr_ok) r_d.err = 1'b1;
                r_d.addr = AW'(1);
                r_d.st   = S_IRD1;
            end
            S_IRD1: begin
                fl_rd  = 1'b1;
                r_d.st = S_ICHK1;
            end
            S_ICHK1: begin
                if (!dev_ok) r_d.err = 1'b1;
                r_d.addr = '0;
                r_d.st   = S_ARR;
            end
            default: r_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st   <= S_IDLE;
            r_q.op   <= OP_PROG;
            r_q.addr <= '0;
            r_q.data <= '0;
            r_q.err  <= 1'b0;
            r_q.done <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign fl_addr  = r_q.addr;
    assign fl_wdata = use_data ? r_q.data : rep(cmd);
    assign done     = r_q.done;
    assign err      = r_q.done & r_q.err;

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8
    op_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st != S_IDLE) |=> $stable(r_q.op));

    // R3
    poll_read_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == S_PRD) |-> ($past(fl_wr) && ($past(fl_wdata) == W_STATUS)));

    // R4
    array_before_verify_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == S_VRD) |-> ($past(fl_wr) && ($past(fl_wdata) == W_ARRAY)));

    // R11
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(fl_wr && fl_rd));

    // R11
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == S_IDLE) |-> (!fl_wr && !fl_rd));
endmodule

// File: tb/tb_nor_cmd_seq.sv
module tb_nor_cmd_seq;
    localparam int AW = 20;
    localparam int DW = 32;
    localparam int PMAX = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [1:0] req_op = 2'b00;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_data = '0;
    logic done, err, fl_wr, fl_rd;
    logic [AW-1:0] fl_addr;
    logic [DW-1:0] fl_wdata;
    logic [DW-1:0] fl_rdata = '0;

    int checks = 0;
    int failures = 0;

    always #10 clk = ~clk;

    nor_cmd_seq #(.NDEV(2), .AW(AW), .POLL_MAX(PMAX)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .req_op(req_op),
        .req_addr(req_addr), .req_data(req_data), .done(done), .err(err),
        .fl_wr(fl_wr), .fl_rd(fl_rd), .fl_addr(fl_addr), .fl_wdata(fl_wdata),
        .fl_rdata(fl_rdata)
    );

    // flash model: two devices sharing one bus
    logic [DW-1:0] mem [64];
    int mode = 0;            // 0 array, 1 status, 2 identifier
    int pend = 0;            // 0 none, 1 program data due, 2 erase confirm due
    int busy_left = 0;
    int busy_cfg = 0;
    bit inj_eerr = 0, inj_perr = 0, half_ready = 0;
    logic [DW-1:0] mfr_val = 32'h00890089;
    logic [DW-1:0] dev_val = 32'h88F388F3;
    logic [AW-1:0] setup_addr = '0;
    int n_wr = 0, n_rd = 0, n_erase = 0, bad_seq = 0;

    initial for (int i = 0; i < 64; i++) mem[i] = '1;

    always @(posedge clk) begin
        if (fl_wr) begin
            n_wr++;
            if (pend == 1) begin
                if (fl_addr != setup_addr) bad_seq++;
                mem[fl_addr[5:0]] = mem[fl_addr[5:0]] & fl_wdata;
                pend = 0; busy_left = busy_cfg; mode = 1;
            end else if (pend == 2) begin
                if (fl_wdata == 32'h00D000D0 && fl_addr == setup_addr) begin
                    for (int i = 0; i < 8; i++) mem[{fl_addr[5:3], 3'(i)}] = '1;
                    n_erase++;
                end else bad_seq++;
                pend = 0; busy_left = busy_cfg; mode = 1;
            end else begin
                case (fl_wdata)
                    32'h00FF00FF: mode = 0;
                    32'h00900090: begin mode = 2; if (fl_addr != '0) bad_seq++; end
                    32'h00700070: mode = 1;
                    32'h00400040: begin pend = 1; setup_addr = fl_addr; end
                    32'h00200020: begin pend = 2; setup_addr = fl_addr; end
                    default: bad_seq++;
                endcase
            end
        end
        if (fl_rd) begin
            n_rd++;
            if (mode == 0) fl_rdata <= mem[fl_addr[5:0]];
            else if (mode == 2) fl_rdata <= (fl_addr == 0) ? mfr_val :
                                            (fl_addr == 1) ? dev_val : '0;
            else if (busy_left > 0) begin
                busy_left--;
                fl_rdata <= half_ready ? 32'h00000080 : 32'h0;
            end else
                fl_rdata <= 32'h00800080 | (inj_eerr ? 32'h00200020 : 0)
                                         | (inj_perr ? 32'h00100010 : 0);
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic run_op(input logic [1:0] op, input logic [AW-1:0] a,
                          input logic [DW-1:0] d, input bit exp_err,
                          input int exp_lat, input string req);
        int lat;
        @(negedge clk);
        start = 1'b1; req_op = op; req_addr = a; req_data = d;
        @(posedge clk); lat = 1;
        @(negedge clk); start = 1'b0;
        while (!done && lat < 200) begin
            @(posedge clk); lat++;
            @(negedge clk);
        end
        chk(lat == exp_lat, {req, " R9 latency"}, lat, exp_lat);
        chk(err == exp_err, {req, " error flag"}, err, exp_err);
        chk(mode == 0, "R4 array mode at done", mode, 0);
        @(negedge clk);
        chk(done == 1'b0, "R9 done single cycle", done, 0);
        chk(err == 1'b0, "R9 err only with done", err, 0);
    endtask

    initial begin
        repeat (1000000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=0x%08h expected=0x%08h", 0, 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int w0, r0;
        logic [DW-1:0] dv;
        repeat (3) @(negedge clk);
        // R11 reset state
        chk(done == 0 && err == 0, "R11 reset outputs", {done, err}, 0);
        chk(fl_wr == 0 && fl_rd == 0, "R11 reset strobes", {fl_wr, fl_rd}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(fl_wr == 0 && fl_rd == 0, "R11 idle strobes", {fl_wr, fl_rd}, 0);

        // R2 R5 program sweep: busy length x status errors
        for (int b = 0; b < 4; b++) begin
            for (int e = 0; e < 4; e++) begin
                busy_cfg = b; inj_perr = e[0]; inj_eerr = e[1];
                dv = 32'h5A3C_0F01 ^ (32'(b * 4 + e) * 32'h01010101);
                run_op(2'b00, AW'(16 + b * 4 + e), dv, e[0], 6 + 3 * (b + 1),
                       "R2 R5 program");
                chk(mem[16 + b * 4 + e] == dv, "R2 programmed word",
                    mem[16 + b * 4 + e], dv);
            end
        end
        inj_perr = 0; inj_eerr = 0;

        // R1 R5 erase sweep
        for (int b = 0; b < 4; b++) begin
            for (int e = 0; e < 4; e++) begin
                busy_cfg = b; inj_eerr = e[0]; inj_perr = e[1];
                mem[{3'(b + 2), 3'(e)}] = 32'h0;
                run_op(2'b01, AW'({3'(b + 2), 3'(7 - e)}), '0, e[0],
                       4 + 3 * (b + 1), "R1 R5 erase");
                chk(mem[{3'(b + 2), 3'(e)}] == '1, "R1 block erased",
                    mem[{3'(b + 2), 3'(e)}], 32'hFFFFFFFF);
            end
        end
        inj_perr = 0; inj_eerr = 0; busy_cfg = 0;

        // R6 read-back mismatch: word already holds zeros
        mem[40] = 32'h0000FFFF;
        run_op(2'b00, AW'(40), 32'hFFFF0000, 1'b1, 9, "R6 verify mismatch");
        run_op(2'b00, AW'(40), 32'h00000000, 1'b0, 9, "R6 verify match");

        // R3 half ready keeps polling
        busy_cfg = 2; half_ready = 1;
        run_op(2'b01, AW'(0), '0, 1'b0, 13, "R3 one lane ready only");
        half_ready = 0;

        // R7 probe sweep
        for (int m = 0; m < 2; m++) begin
            for (int d = 0; d < 4; d++) begin
                mfr_val = (m == 0) ? 32'h00890089 : 32'h00890088;
                dev_val = (d == 0) ? 32'h88F388F3 : (d == 1) ? 32'h88F488F4 :
                          (d == 2) ? 32'h88F188F1 : 32'h88F388F4;
                run_op(2'b10, AW'(5), '0, !(m == 0 && d < 2), 7, "R7 probe");
            end
        end

        // R10 timeout
        busy_cfg = 100;
        run_op(2'b01, AW'(8), '0, 1'b1, 4 + 3 * PMAX, "R10 erase timeout");
        run_op(2'b00, AW'(50), 32'h12345678, 1'b1, 6 + 3 * PMAX,
               "R10 program timeout");
        busy_cfg = 0;

        // R8 start while busy is ignored
        w0 = n_erase;
        @(negedge clk);
        start = 1'b1; req_op = 2'b00; req_addr = AW'(60); req_data = 32'hCAFE0001;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        start = 1'b1; req_op = 2'b01; req_addr = AW'(60);
        @(negedge clk);
        start = 1'b0;
        begin
            int g = 0;
            while (!done && g < 200) begin @(negedge clk); g++; end
        end
        chk(err == 1'b0, "R8 busy start ignored, program ok", err, 0);
        repeat (20) @(negedge clk);
        chk(n_erase == w0, "R8 no erase from busy start", n_erase, w0);
        chk(mem[60] == 32'hCAFE0001, "R8 word kept", mem[60], 32'hCAFE0001);

        // R8 reserved op ignored
        w0 = n_wr; r0 = n_rd;
        @(negedge clk);
        start = 1'b1; req_op = 2'b11;
        @(negedge clk);
        start = 1'b0;
        begin
            int seen = 0;
            for (int k = 0; k < 15; k++) begin
                @(negedge clk);
                if (done) seen++;
            end
            chk(seen == 0, "R8 reserved op no done", seen, 0);
        end
        chk(n_wr == w0 && n_rd == r0, "R8 reserved op no bus", n_wr - w0, 0);
        chk(bad_seq == 0, "R1 R2 R7 command sequence", bad_seq, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule